// File: doc/BRIEF.md
# Line Capture Register for a Column Driver

This block collects one display line for a column driver with 312 outputs. A word of six 6-bit gray codes arrives on each shift clock. A write pointer, armed by a start pulse, steers each word into the next group of six output slots. 312 outputs at six codes per word make 52 groups. The finished line is presented as one flat register, `line_o`, for a downstream line latch.

Direction control does three things. It picks the fill order: first output to last, or the reverse. It picks which of the two start pins listens for the start pulse. It picks which start pin carries the cascade pulse to the next driver in the chain. The cascade pulse fires on the clock that fills the last group. After two further clocks the pass ends. A rising strobe aborts a running pass.

The word input has no valid/ready pair and no back-pressure. The source presents a fresh word on every shift clock, and the block either consumes it or ignores it, depending only on where the pass stands. The start pins are modelled as split in, out and output-enable signals.

Top module: `lcap_line_capture`

## Requirements
- R1: After reset no pass is running, `line_o` is all zero, and both start-pin outputs are low.
- R2: Code c of a word occupies `word_i[6c+5:6c]`, with bit 0 as the LSB. Output n (1..312) occupies `line_o[6(n-1)+5:6(n-1)]`.
- R3: With `dir_i`=1 at the clock edge that samples the start pulse (edge t0), the word present at edge t0+k (k=1..52) is stored so that code c lands on output 6(k-1)+1+c.
- R4: With `dir_i`=0 at edge t0, the word present at edge t0+k is stored so that code c lands on output 312-6(k-1)-c.
- R5: With `dir_i`=1, `start_r_i` is the start input and `start_l_i` is ignored; `start_r_oe`=0 and `start_l_oe`=1. With `dir_i`=0 the roles swap. A pin whose enable is low has its output driven low.
- R6: The cascade pin (`start_l_o` when `dir_i`=1, `start_r_o` when `dir_i`=0) is high for exactly the one cycle after edge t0+52, and low at all other times.
- R7: A pass ends at edge t0+54. A start pulse sampled at edges t0+1 to t0+54 is ignored. A start pulse sampled at edge t0+55 or later begins a new pass.
- R8: While no pass is running, `line_o` holds its contents whatever `word_i` carries.
- R9: A rising strobe (`strobe_i` high at an edge and low at the previous edge) ends any running pass at that edge. That word is not stored, no cascade pulse follows, and a start pulse at the same edge is ignored. A strobe held high does not block later start pulses.
- R10: The fill order is fixed by `dir_i` at edge t0; changing `dir_i` during the pass does not alter where later words land.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_i | input | 1 | 1: fill from output 1 upward; 0: fill from output 312 downward |
| strobe_i | input | 1 | Line strobe; its rising edge aborts a pass |
| word_i | input | 36 | Six 6-bit gray codes |
| start_r_i | input | 1 | Right start pin, input side |
| start_r_o | output | 1 | Right start pin, output side (cascade when `dir_i`=0) |
| start_r_oe | output | 1 | Right start pin output enable |
| start_l_i | input | 1 | Left start pin, input side |
| start_l_o | output | 1 | Left start pin, output side (cascade when `dir_i`=1) |
| start_l_oe | output | 1 | Left start pin output enable |
| line_o | output | 1872 | Captured line, six bits per output |

## Verification
The word sampled at edge t0+k is due on `line_o` right after that edge, so it is visible one cycle of state update after the clock that carries it. The cascade pulse is due in the cycle after edge t0+52. Pin enables follow `dir_i` with no delay. The bench keeps a behavioural model that advances on each rising edge from the same inputs, then compares the full line and all pin outputs at the following falling edge. Every result is therefore judged exactly one register stage after the edge that produced it. Inputs change only at falling edges.

// File: rtl/lcap_pkg.sv
package lcap_pkg;
  typedef enum logic {
    FILL_DOWN = 1'b0,
    FILL_UP   = 1'b1
  } fill_dir_e;

  localparam int unsigned DEF_OUTPUTS   = 312;
  localparam int unsigned DEF_CODES     = 6;
  localparam int unsigned DEF_CODE_W    = 6;
  localparam int unsigned DEF_TAIL_CLKS = 2;
endpackage

// File: rtl/lcap_start_pins.sv
module lcap_start_pins (
  input  logic dir_i,
  input  logic casc_i,
  input  logic start_r_i,
  input  logic start_l_i,
  output logic start_o,
  output logic start_r_o,
  output logic start_r_oe,
  output logic start_l_o,
  output logic start_l_oe
);
  import lcap_pkg::*;

  logic up;
  assign up = (fill_dir_e'(dir_i) == FILL_UP);

  // The input role goes to the pin at the near end of the fill order.
  assign start_o    = up ? start_r_i : start_l_i;
  assign start_r_oe = ~up;
  assign start_l_oe = up;
  assign start_r_o  = casc_i & ~up;
  assign start_l_o  = casc_i & up;
endmodule

// File: rtl/lcap_ptr_ctl.sv
module lcap_ptr_ctl #(
  parameter int unsigned NGRP = 52,
  parameter int unsigned TAIL = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            dir_i,
  input  logic            strobe_i,
  output logic            busy_o,
  output logic            rev_o,
  output logic            casc_o,
  output logic [NGRP-1:0] grp_we_o
);
  import lcap_pkg::*;

  localparam int unsigned LAST = NGRP + TAIL;
  localparam int unsigned CW   = $clog2(LAST + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q, stb_q, casc_q;
  fill_dir_e     dir_q;
  logic          stb_rise, wr_act;

  assign stb_rise = strobe_i & ~stb_q;
  assign wr_act   = busy_q & ~stb_rise & (cnt_q <= CW'(NGRP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      dir_q  <= FILL_UP;
      stb_q  <= 1'b0;
      casc_q <= 1'b0;
    end else begin
      stb_q  <= strobe_i;
      casc_q <= 1'b0;
      if (busy_q) begin
        if (stb_rise) begin
          busy_q <= 1'b0;
        end else begin
          if (cnt_q == CW'(NGRP)) casc_q <= 1'b1;
          if (cnt_q == CW'(LAST)) busy_q <= 1'b0;
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (start_i && !stb_rise) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(1);
        dir_q  <= fill_dir_e'(dir_i);
      end
    end
  end

  // Decode the logical group number onto the physical group it targets.
  for (genvar g = 0; g < NGRP; g++) begin : g_we
    localparam logic [CW-1:0] IDX_UP = CW'(g + 1);
    localparam logic [CW-1:0] IDX_DN = CW'(NGRP - g);
    assign grp_we_o[g] = wr_act &
                         (cnt_q == ((dir_q == FILL_UP) ? IDX_UP : IDX_DN));
  end

  assign busy_o = busy_q;
  assign rev_o  = (dir_q == FILL_DOWN);
  assign casc_o = casc_q;
endmodule

// File: rtl/lcap_line_reg.sv
module lcap_line_reg #(
  parameter int unsigned NGRP   = 52,
  parameter int unsigned CODES  = 6,
  parameter int unsigned CODE_W = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NGRP-1:0]               grp_we_i,
  input  logic                          rev_i,
  input  logic [CODES*CODE_W-1:0]       word_i,
  output logic [NGRP*CODES*CODE_W-1:0]  line_o
);
  localparam int unsigned GW = CODES * CODE_W;

  logic [GW-1:0] word_rev;

  // Mirror the code order for a downward fill.
  for (genvar j = 0; j < CODES; j++) begin : g_mir
    assign word_rev[j*CODE_W +: CODE_W] = word_i[(CODES-1-j)*CODE_W +: CODE_W];
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [GW-1:0] grp_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           grp_q <= '0;
      else if (grp_we_i[g]) grp_q <= rev_i ? word_rev : word_i;
    end
    assign line_o[g*GW +: GW] = grp_q;
  end
endmodule

// File: rtl/lcap_line_capture.sv
module lcap_line_capture #(
  parameter int unsigned N_OUT     = lcap_pkg::DEF_OUTPUTS,
  parameter int unsigned CODES     = lcap_pkg::DEF_CODES,
  parameter int unsigned CODE_W    = lcap_pkg::DEF_CODE_W,
  parameter int unsigned TAIL_CLKS = lcap_pkg::DEF_TAIL_CLKS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      dir_i,
  input  logic                      strobe_i,
  input  logic [CODES*CODE_W-1:0]   word_i,
  input  logic                      start_r_i,
  output logic                      start_r_o,
  output logic                      start_r_oe,
  input  logic                      start_l_i,
  output logic                      start_l_o,
  output logic                      start_l_oe,
  output logic [N_OUT*CODE_W-1:0]   line_o
);
  localparam int unsigned NGRP = N_OUT / CODES;
  localparam int unsigned LW   = N_OUT * CODE_W;

  logic            start_w, busy_w, rev_w, casc_w;
  logic [NGRP-1:0] grp_we_w;

  lcap_start_pins u_pins (
    .dir_i      (dir_i),
    .casc_i     (casc_w),
    .start_r_i  (start_r_i),
    .start_l_i  (start_l_i),
    .start_o    (start_w),
    .start_r_o  (start_r_o),
    .start_r_oe (start_r_oe),
    .start_l_o  (start_l_o),
    .start_l_oe (start_l_oe)
  );

  lcap_ptr_ctl #(.NGRP(NGRP), .TAIL(TAIL_CLKS)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_w),
    .dir_i    (dir_i),
    .strobe_i (strobe_i),
    .busy_o   (busy_w),
    .rev_o    (rev_w),
    .casc_o   (casc_w),
    .grp_we_o (grp_we_w)
  );

  lcap_line_reg #(.NGRP(NGRP), .CODES(CODES), .CODE_W(CODE_W)) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .grp_we_i (grp_we_w),
    .rev_i    (rev_w),
    .word_i   (word_i),
    .line_o   (line_o)
  );
endmodule

// File: rtl/lcap_line_capture_chk.sv
module lcap_line_capture_chk #(
  parameter int unsigned NGRP = 52,
  parameter int unsigned LW   = 1872
) (
  input logic            clk,
  input logic            rst_n,
  input logic            strobe_i,
  input logic            start_r_o,
  input logic            start_r_oe,
  input logic            start_l_o,
  input logic            start_l_oe,
  input logic            busy,
  input logic [NGRP-1:0] grp_we,
  input logic [LW-1:0]   line_o
);
  AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grp_we)); // R3

  AST_PIN_ROLES: assert property (@(posedge clk) disable iff (!rst_n)
    start_r_oe != start_l_oe); // R5

  AST_RIGHT_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !start_r_oe |-> !start_r_o); // R5

  AST_LEFT_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !start_l_oe |-> !start_l_o); // R5

  AST_CASC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_r_o || start_l_o) |=> !(start_r_o || start_l_o)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(line_o)); // R8

  AST_STB_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && !$past(strobe_i)) |=> !busy); // R9

  AST_STB_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && !$past(strobe_i)) |-> (grp_we == '0)); // R9
endmodule

bind lcap_line_capture lcap_line_capture_chk #(.NGRP(NGRP), .LW(LW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .strobe_i   (strobe_i),
  .start_r_o  (start_r_o),
  .start_r_oe (start_r_oe),
  .start_l_o  (start_l_o),
  .start_l_oe (start_l_oe),
  .busy       (busy_w),
  .grp_we     (grp_we_w),
  .line_o     (line_o)
);

// File: tb/lcap_line_capture_tb.sv
module lcap_line_capture_tb_top;
  localparam int NOUT = 312;
  localparam int NG   = 52;
  localparam int LAST = 54;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dir = 1'b1, stb = 1'b0, sr_in = 1'b0, sl_in = 1'b0;
  logic [35:0]   word = '0;
  logic          sr_out, sr_oe, sl_out, sl_oe;
  logic [NOUT*6-1:0] line;

  int n_checks = 0, n_fails = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural reference state
  int m_line[NOUT];
  bit m_busy, m_dir, m_stbp, m_casc;
  int m_cnt;

  always #5 clk = ~clk;

  lcap_line_capture dut_i (
    .clk(clk), .rst_n(rst_n), .dir_i(dir), .strobe_i(stb), .word_i(word),
    .start_r_i(sr_in), .start_r_o(sr_out), .start_r_oe(sr_oe),
    .start_l_i(sl_in), .start_l_o(sl_out), .start_l_oe(sl_oe),
    .line_o(line)
  );

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  task automatic model_step();
    bit rise, st;
    rise = stb && !m_stbp;
    m_stbp = stb;
    m_casc = 0;
    if (!rst_n) begin
      foreach (m_line[i]) m_line[i] = 0;
      m_busy = 0; m_cnt = 0; m_dir = 1; m_stbp = 0;
      return;
    end
    st = dir ? sr_in : sl_in;
    if (m_busy) begin
      if (rise) m_busy = 0;
      else begin
        if (m_cnt <= NG) begin
          for (int c = 0; c < 6; c++) begin
            int o;
            o = m_dir ? 6*(m_cnt-1)+1+c : NOUT-6*(m_cnt-1)-c;
            m_line[o-1] = int'((word >> (6*c)) & 36'h3F);
          end
        end
        if (m_cnt == NG) m_casc = 1;
        if (m_cnt == LAST) m_busy = 0;
        m_cnt++;
      end
    end else if (st && !rise) begin
      m_busy = 1; m_cnt = 1; m_dir = dir;
    end
  endtask

  task automatic compare();
    logic [NOUT*6-1:0] exp_line;
    logic [3:0] exp_pins, got_pins;
    for (int n = 0; n < NOUT; n++) exp_line[6*n +: 6] = 6'(m_line[n]);
    n_checks++;
    if (line !== exp_line) begin
      n_fails++;
      $display("FAIL %s line: actual %h expected %h", tag, line, exp_line);
    end
    exp_pins = {m_casc && !dir, !dir, m_casc && dir, dir};
    got_pins = {sr_out, sr_oe, sl_out, sl_oe};
    n_checks++;
    if (got_pins !== exp_pins) begin
      n_fails++;
      $display("FAIL %s pins {r_o,r_oe,l_o,l_oe}: actual %b expected %b", tag, got_pins, exp_pins);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      word = {4'($urandom), 32'($urandom)};
      cyc();
    end
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    tag = "R1";
    tick(3);
    @(negedge clk) rst_n = 1'b1;
    compare();

    // R3/R2: upward fill from right pin; R7 ignored starts mid-pass
    tag = "R3";
    dir = 1; sr_in = 1; tick(); sr_in = 0;   // edge t0
    tick(29);                                // clocks 1..29
    tag = "R7"; sr_in = 1; tick(); sr_in = 0; // clock 30 ignored
    tag = "R3"; tick(21);                    // 31..51
    tag = "R6"; tick(2);                     // 52 (cascade), 53
    tag = "R7"; sr_in = 1; tick(); sr_in = 0; // clock 54 ignored
    sr_in = 1; tick(); sr_in = 0;            // clock 55 starts new pass
    tag = "R3"; tick(56);

    // R8: idle hold with changing words
    tag = "R8"; tick(8);

    // R5: wrong pin ignored, then downward fill from left pin
    tag = "R5"; dir = 1; sl_in = 1; tick(); sl_in = 0; tick(4);
    tag = "R4"; dir = 0; sl_in = 1; tick(); sl_in = 0;
    tick(58);
    tag = "R5"; sr_in = 1; tick(); sr_in = 0; tick(4);

    // R9: strobe abort, held strobe, same-edge start
    tag = "R9"; dir = 1; sr_in = 1; tick(); sr_in = 0;
    tick(20);
    stb = 1; tick(10);
    sr_in = 1; tick(); sr_in = 0; tick(5);
    stb = 0; tick();
    stb = 1; sr_in = 1; tick(); sr_in = 0;
    tick(60);
    stb = 0; tick(2);

    // R10: direction change mid-pass does not alter fill order
    tag = "R10"; dir = 1; sr_in = 1; tick(); sr_in = 0;
    tick(10);
    dir = 0; tick(50);

    done = 1;
    report();
    $finish;
  end
endmodule